// File: doc/BRIEF.md
# FM Operator Envelope Generator with Repeating Envelope Mode

This block produces the loudness envelope for one operator of a four-operator FM voice. It holds a 10-bit attenuation value and a five-state envelope state, and advances both once per envelope tick. The caller supplies the increment shift already looked up from the current rate, the sustain level, the total level and the attack rate plus key scaling. The block returns the state, the raw attenuation and the output attenuation that the operator's level path consumes.

A four-bit control field selects the repeating envelope mode. In that mode the envelope climbs four times faster, and only through the lower half of the range. When the attenuation reaches the half-range point the envelope either restarts, holds, or flips its output direction. The mode can also ask the phase accumulator to restart through a one-cycle strobe. Key-on and key-off act on the next clock edge whether or not a tick is present.

Top module: `fm_env_gen`

## Requirements
- R1: A synchronous reset sets the state to off and the attenuation to 1023, with the phase strobe low. The state codes are off=0, release=1, sustain=2, decay=3, attack=4.
- R2: Key-on sets the state to attack and clears the invert and hold-lock flags, leaving the attenuation unchanged. Otherwise, key-off sets any state other than off to release. Key-on wins over key-off, and either one wins over a tick in the same cycle.
- R3: In the off state a tick changes neither the state nor the attenuation.
- R4: On a tick in attack with shift s>=1, the attenuation A becomes A + ((~A) <<< (s-1)) >>> 4 in 32-bit signed arithmetic. When the result is 0 or below, A becomes 0 and the state becomes sustain if the sustain level is 0, and decay otherwise. With s=0 only the exit check runs.
- R5: Outside the repeating mode a decay tick adds inc = (s==0 ? 0 : 1<<(s-1)) and saturates at 1023. The state moves to sustain once A >= sustain level.
- R6: Outside the repeating mode a sustain tick adds inc and saturates at 1023. A release tick adds inc, and on reaching 1023 it clamps there and moves to off.
- R7: ssg_ctl bit 3 enables the repeating mode, bit 2 inverts, bit 1 alternates and bit 0 holds. In this mode a decay, sustain or release tick adds 4*inc only while A < 512. A release tick that leaves A >= 512 sets A to 1023 and the state to off.
- R8: A repeat event occurs on a tick with the mode enabled, the state above release and A >= 512. With hold set, alternate toggles the invert flag on the first held repeat only. A is then forced to 1023 unless the state is attack or (bit 2 XOR invert flag) is 1.
- R9: In a repeat event with hold clear, alternate toggles the invert flag, and without alternate the phase strobe is raised. A state other than attack restarts: if the attack rate is >= 94, A becomes 0 and the state becomes sustain or decay by the sustain level; otherwise the state becomes attack.
- R10: out_att equals the total level plus either ((512 - A) mod 1024), when the mode is enabled, (bit 2 XOR invert flag) is 1 and the state is above release, or A in all other cases.
- R11: Within one tick the repeat event is applied first and the state update then runs on its result. The phase strobe is high for the single cycle after the tick that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Envelope tick strobe |
| key_on | input | 1 | Start the envelope in attack |
| key_off | input | 1 | Move the envelope to release |
| inc_shift | input | 4 | Increment shift for the current rate |
| sus_lvl | input | 10 | Sustain level in attenuation units |
| total_lvl | input | 10 | Total level added to the output |
| ssg_ctl | input | 4 | Repeating mode: [3] enable, [2] invert, [1] alternate, [0] hold |
| atk_rate | input | 7 | Attack rate plus key scaling |
| env_state | output | 3 | Current envelope state |
| env_att | output | 10 | Raw attenuation |
| out_att | output | 11 | Output attenuation including total level |
| phase_rst | output | 1 | One-cycle request to restart the operator phase |

## Verification
The assertions assume that every input is synchronous and settled at the rising edge. They also assume a tick is a single-cycle strobe whose companion inputs (shift, levels, control bits) are valid in that same cycle. The stimulus drives all inputs on the falling edge and holds them for exactly one cycle. It keeps key events sparse so that long attack, decay and repeat sequences develop between them. It also changes the mode control bits only now and then, so that hold and alternate sequences run to their end.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

    localparam int ATT_W    = 10;
    localparam int ATT_MAX  = (1 << ATT_W) - 1;
    localparam int ATT_HALF = 1 << (ATT_W - 1);

    localparam int SSG_HOLD = 0;
    localparam int SSG_ALT  = 1;
    localparam int SSG_INV  = 2;
    localparam int SSG_EN   = 3;

    typedef enum logic [2:0] {
        ST_OFF = 3'd0,
        ST_REL = 3'd1,
        ST_SUS = 3'd2,
        ST_DEC = 3'd3,
        ST_ATK = 3'd4
    } env_state_e;

    typedef struct packed {
        env_state_e        state;
        logic [ATT_W-1:0]  att;
        logic              inv;
        logic              held;
        logic              prst;
    } env_regs_t;

endpackage

// File: rtl/fm_env_repeat.sv
module fm_env_repeat
    import fm_env_pkg::*;
#(
    parameter int RATE_W   = 7,
    parameter int FAST_ATK = 94
) (
    input  logic              fire,
    input  env_state_e        state_i,
    input  logic [ATT_W-1:0]  att_i,
    input  logic              inv_i,
    input  logic              held_i,
    input  logic [3:0]        ssg_ctl,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [ATT_W-1:0]  sus_lvl,
    output env_state_e        state_o,
    output logic [ATT_W-1:0]  att_o,
    output logic              inv_o,
    output logic              held_o,
    output logic              prst_o
);
    localparam logic [RATE_W-1:0] FAST_V = RATE_W'(FAST_ATK);
    localparam logic [ATT_W-1:0]  FULL_V = '1;

    env_state_e after_zero;

    always_comb begin
        after_zero = (sus_lvl == '0) ? ST_SUS : ST_DEC;
        state_o    = state_i;
        att_o      = att_i;
        inv_o      = inv_i;
        held_o     = held_i;
        prst_o     = 1'b0;
        if (fire) begin
            if (ssg_ctl[SSG_HOLD]) begin
                if (ssg_ctl[SSG_ALT] && !held_i) begin
                    inv_o = !inv_i;
                end
                held_o = 1'b1;
                if ((state_i != ST_ATK) && !(ssg_ctl[SSG_INV] ^ inv_o)) begin
                    att_o = FULL_V;
                end
            end else begin
                if (ssg_ctl[SSG_ALT]) begin
                    inv_o = !inv_i;
                end else begin
                    prst_o = 1'b1;
                end
                if (state_i != ST_ATK) begin
                    if (atk_rate >= FAST_V) begin
                        att_o   = '0;
                        state_o = after_zero;
                    end else if (att_i != '0) begin
                        state_o = ST_ATK;
                    end else begin
                        state_o = after_zero;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fm_env_step.sv
module fm_env_step
    import fm_env_pkg::*;
#(
    parameter int SHIFT_W = 4
) (
    input  env_state_e         state_i,
    input  logic [ATT_W-1:0]   att_i,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ATT_W-1:0]   sus_lvl,
    input  logic               ssg_en,
    output env_state_e         state_o,
    output logic [ATT_W-1:0]   att_o
);
    localparam logic signed [31:0] MAX_S  = 32'(ATT_MAX);
    localparam logic signed [31:0] HALF_S = 32'(ATT_HALF);

    logic signed [31:0] base;
    logic signed [31:0] inc;
    logic signed [31:0] add;
    logic signed [31:0] delta;
    logic signed [31:0] acc;
    logic signed [31:0] sus_s;
    env_state_e         after_zero;

    always_comb begin
        base       = 32'(att_i);
        sus_s      = 32'(sus_lvl);
        inc        = (shift == '0) ? 32'sd0 : (32'sd1 <<< (shift - 1'b1));
        add        = ssg_en ? ((base < HALF_S) ? (inc <<< 2) : 32'sd0) : inc;
        after_zero = (sus_lvl == '0) ? ST_SUS : ST_DEC;
        delta      = 32'sd0;
        acc        = base;
        state_o    = state_i;
        case (state_i)
            ST_ATK: begin
                if (shift != '0) begin
                    delta = (~base) <<< (shift - 1'b1);
                    delta = delta >>> 4;
                    acc   = base + delta;
                end
                if (acc <= 32'sd0) begin
                    acc     = 32'sd0;
                    state_o = after_zero;
                end
            end
            ST_DEC: begin
                acc = base + add;
                if (acc > MAX_S) acc = MAX_S;
                if (acc >= sus_s) state_o = ST_SUS;
            end
            ST_SUS: begin
                acc = base + add;
                if (acc > MAX_S) acc = MAX_S;
            end
            ST_REL: begin
                acc = base + add;
                if (ssg_en) begin
                    if (acc >= HALF_S) begin
                        acc     = MAX_S;
                        state_o = ST_OFF;
                    end
                end else if (acc >= MAX_S) begin
                    acc     = MAX_S;
                    state_o = ST_OFF;
                end
            end
            default: begin
                acc = base;
            end
        endcase
        att_o = acc[ATT_W-1:0];
    end

endmodule

// File: rtl/fm_env_out.sv
module fm_env_out
    import fm_env_pkg::*;
(
    input  env_state_e       state_i,
    input  logic [ATT_W-1:0] att_i,
    input  logic             inv_i,
    input  logic [3:0]       ssg_ctl,
    input  logic [ATT_W-1:0] total_lvl,
    output logic [ATT_W:0]   out_att
);
    localparam logic [ATT_W-1:0] HALF_V = ATT_W'(ATT_HALF);

    logic             flip;
    logic [ATT_W-1:0] shaped;

    always_comb begin
        flip    = ssg_ctl[SSG_EN] && (ssg_ctl[SSG_INV] ^ inv_i) && (state_i > ST_REL);
        shaped  = flip ? (HALF_V - att_i) : att_i;
        out_att = {1'b0, shaped} + {1'b0, total_lvl};
    end

endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
    import fm_env_pkg::*;
#(
    parameter int SHIFT_W  = 4,
    parameter int RATE_W   = 7,
    parameter int FAST_ATK = 94
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               key_on,
    input  logic               key_off,
    input  logic [SHIFT_W-1:0] inc_shift,
    input  logic [ATT_W-1:0]   sus_lvl,
    input  logic [ATT_W-1:0]   total_lvl,
    input  logic [3:0]         ssg_ctl,
    input  logic [RATE_W-1:0]  atk_rate,
    output logic [2:0]         env_state,
    output logic [ATT_W-1:0]   env_att,
    output logic [ATT_W:0]     out_att,
    output logic               phase_rst
);
    localparam logic [ATT_W-1:0] HALF_V = ATT_W'(ATT_HALF);
    localparam env_regs_t RESET_V = '{state: ST_OFF, att: '1, inv: 1'b0,
                                      held: 1'b0, prst: 1'b0};

    env_regs_t        regs_q, regs_d;
    logic             rep_fire;
    env_state_e       rep_state;
    logic [ATT_W-1:0] rep_att;
    logic             rep_inv, rep_held, rep_prst;
    env_state_e       step_state;
    logic [ATT_W-1:0] step_att;

    assign rep_fire = tick && ssg_ctl[SSG_EN] && (regs_q.state > ST_REL)
                      && (regs_q.att >= HALF_V);

    fm_env_repeat #(.RATE_W(RATE_W), .FAST_ATK(FAST_ATK)) rep_i (
        .fire     (rep_fire),
        .state_i  (regs_q.state),
        .att_i    (regs_q.att),
        .inv_i    (regs_q.inv),
        .held_i   (regs_q.held),
        .ssg_ctl  (ssg_ctl),
        .atk_rate (atk_rate),
        .sus_lvl  (sus_lvl),
        .state_o  (rep_state),
        .att_o    (rep_att),
        .inv_o    (rep_inv),
        .held_o   (rep_held),
        .prst_o   (rep_prst)
    );

    fm_env_step #(.SHIFT_W(SHIFT_W)) step_i (
        .state_i (rep_state),
        .att_i   (rep_att),
        .shift   (inc_shift),
        .sus_lvl (sus_lvl),
        .ssg_en  (ssg_ctl[SSG_EN]),
        .state_o (step_state),
        .att_o   (step_att)
    );

    fm_env_out out_i (
        .state_i   (regs_q.state),
        .att_i     (regs_q.att),
        .inv_i     (regs_q.inv),
        .ssg_ctl   (ssg_ctl),
        .total_lvl (total_lvl),
        .out_att   (out_att)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.prst = 1'b0;
        if (key_on) begin
            regs_d.state = ST_ATK;
            regs_d.inv   = 1'b0;
            regs_d.held  = 1'b0;
        end else if (key_off) begin
            if (regs_q.state != ST_OFF) regs_d.state = ST_REL;
        end else if (tick && (regs_q.state != ST_OFF)) begin
            regs_d.state = step_state;
            regs_d.att   = step_att;
            regs_d.inv   = rep_inv;
            regs_d.held  = rep_held;
            regs_d.prst  = rep_prst;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= RESET_V;
        else     regs_q <= regs_d;
    end

    assign env_state = regs_q.state;
    assign env_att   = regs_q.att;
    assign phase_rst = regs_q.prst;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        env_state <= 3'd4); // R1
    AST_KEYON_ATTACK: assert property (@(posedge clk) disable iff (rst)
        key_on |=> (env_state == 3'd4) && !phase_rst); // R2
    AST_KEYOFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!key_on && key_off && env_state != 3'd0) |=> env_state == 3'd1); // R2
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (env_state == 3'd0 && !key_on) |=> (env_state == 3'd0) && $stable(env_att)); // R3
    AST_ATTACK_FALLS: assert property (@(posedge clk) disable iff (rst)
        (env_state == 3'd4 && !key_on && !key_off) |=> env_att <= $past(env_att)); // R4
    AST_SSG_RELEASE_CAP: assert property (@(posedge clk) disable iff (rst)
        (tick && ssg_ctl[SSG_EN] && env_state == 3'd1 && !key_on && !key_off)
        |=> (env_state == 3'd0) || (env_att < HALF_V)); // R7
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        phase_rst |-> $past(tick) && $past(ssg_ctl[SSG_EN]) && !$past(ssg_ctl[SSG_HOLD])); // R9
    AST_PLAIN_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !ssg_ctl[SSG_EN] |-> out_att == ({1'b0, env_att} + {1'b0, total_lvl})); // R10

endmodule

// File: tb/fm_env_gen_tb_top.sv
module fm_env_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst, tick, key_on, key_off;
    logic [3:0] inc_shift;
    logic [9:0] sus_lvl, total_lvl;
    logic [3:0] ssg_ctl;
    logic [6:0] atk_rate;
    logic [2:0] env_state;
    logic [9:0] env_att;
    logic [10:0] out_att;
    logic       phase_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_st, m_att, m_inv, m_held, m_pr;

    always #10 clk = ~clk;

    fm_env_gen dut_i (
        .clk(clk), .rst(rst), .tick(tick), .key_on(key_on), .key_off(key_off),
        .inc_shift(inc_shift), .sus_lvl(sus_lvl), .total_lvl(total_lvl),
        .ssg_ctl(ssg_ctl), .atk_rate(atk_rate), .env_state(env_state),
        .env_att(env_att), .out_att(out_att), .phase_rst(phase_rst)
    );

    function automatic int zero_exit(int sl);
        return (sl == 0) ? 2 : 3;
    endfunction

    function automatic int exp_out();
        int sel;
        sel = m_att;
        if (ssg_ctl[3] && ((ssg_ctl[2] ? 1 : 0) != m_inv) && m_st > 1)
            sel = (512 - m_att) & 1023;
        return sel + int'(total_lvl);
    endfunction

    // Next-state model written from R1..R11.
    task automatic model_step();
        int a, s, sh, inc, add, d, sl;
        bit en;
        m_pr = 0;
        if (rst) begin
            m_st = 0; m_att = 1023; m_inv = 0; m_held = 0;
            return;
        end
        if (key_on) begin
            m_st = 4; m_inv = 0; m_held = 0;
            return;
        end
        if (key_off) begin
            if (m_st != 0) m_st = 1;
            return;
        end
        if (!tick || m_st == 0) return;
        a = m_att; s = m_st; sh = int'(inc_shift); sl = int'(sus_lvl); en = ssg_ctl[3];
        // repeat event first (R11)
        if (en && s > 1 && a >= 512) begin
            if (ssg_ctl[0]) begin
                if (ssg_ctl[1] && m_held == 0) m_inv = 1 - m_inv;
                m_held = 1;
                if (s != 4 && ((ssg_ctl[2] ? 1 : 0) == m_inv)) a = 1023;
            end else begin
                if (ssg_ctl[1]) m_inv = 1 - m_inv; else m_pr = 1;
                if (s != 4) begin
                    if (atk_rate >= 7'd94) begin a = 0; s = zero_exit(sl); end
                    else if (a != 0) s = 4;
                    else s = zero_exit(sl);
                end
            end
        end
        inc = (sh == 0) ? 0 : (1 << (sh - 1));
        add = en ? ((a < 512) ? 4 * inc : 0) : inc;
        case (s)
            4: begin
                if (sh >= 1) begin
                    d = (-(a + 1)) <<< (sh - 1);
                    d = d >>> 4;
                    a = a + d;
                end
                if (a <= 0) begin a = 0; s = zero_exit(sl); end
            end
            3: begin
                a = a + add; if (a > 1023) a = 1023;
                if (a >= sl) s = 2;
            end
            2: begin
                a = a + add; if (a > 1023) a = 1023;
            end
            1: begin
                a = a + add;
                if (en) begin
                    if (a >= 512) begin a = 1023; s = 0; end
                end else if (a >= 1023) begin a = 1023; s = 0; end
            end
            default: ;
        endcase
        m_att = a; m_st = s;
    endtask

    task automatic check_one(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check_one(tag, "state", int'(env_state), m_st);
        check_one(tag, "att", int'(env_att), m_att);
        check_one(tag, "phase_rst", int'(phase_rst), m_pr);
        check_one(tag, "out_att", int'(out_att), exp_out());
    endtask

    task automatic step_cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle_inputs();
        tick = 0; key_on = 0; key_off = 0;
    endtask

    task automatic press_key(bit on, string tag);
        idle_inputs();
        if (on) key_on = 1; else key_off = 1;
        step_cyc(tag);
        idle_inputs();
    endtask

    task automatic ticks_until(int n, int stop_state, string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            step_cyc(tag);
            if (m_st == stop_state) break;
        end
        tick = 0;
    endtask

    function automatic string tag_for(int st, bit en);
        if (st == 4) return "R4";
        if (en && st > 1) return "R8";
        if (en) return "R7";
        if (st == 3) return "R5";
        if (st == 0) return "R3";
        return "R6";
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; idle_inputs();
        inc_shift = 4'd4; sus_lvl = 10'd256; total_lvl = 10'd0;
        ssg_ctl = 4'b0000; atk_rate = 7'd20;
        @(negedge clk);
        step_cyc("R1");
        rst = 0;

        // R3: ticks in off change nothing
        ticks_until(3, 9, "R3");

        // R2 + R4: attack from 1023 with shift 4, exit to decay
        press_key(1, "R2");
        ticks_until(40, 3, "R4");
        // R5: decay to sustain level
        inc_shift = 4'd3;
        ticks_until(200, 2, "R5");
        // R6: sustain saturates
        inc_shift = 4'd15;
        ticks_until(2, 9, "R6");
        // R6: release to off
        press_key(0, "R2");
        inc_shift = 4'd1;
        ticks_until(2, 0, "R6");
        // R2: key-on beats key-off
        idle_inputs(); key_on = 1; key_off = 1; step_cyc("R2"); idle_inputs();
        // R4: shift 0 in attack stays put
        inc_shift = 4'd0; ticks_until(2, 9, "R4");
        // attack to zero with sustain 0 -> sustain directly
        sus_lvl = 10'd0; inc_shift = 4'd9; ticks_until(20, 2, "R4");

        // R7 + R9 + R11: repeating mode, no hold, no alternate -> strobe + restart
        ssg_ctl = 4'b1000; inc_shift = 4'd6; atk_rate = 7'd20;
        ticks_until(20, 4, "R9");
        idle_inputs(); step_cyc("R11");
        inc_shift = 4'd10; ticks_until(20, 2, "R4");
        // R10: alternate flips the output
        ssg_ctl = 4'b1010; inc_shift = 4'd6;
        ticks_until(20, 4, "R10");
        for (int i = 0; i < 6; i++) begin tick = 1; step_cyc("R10"); end
        idle_inputs();
        // R9: fast attack shortcut
        ssg_ctl = 4'b1000; atk_rate = 7'd100; sus_lvl = 10'd40;
        for (int i = 0; i < 12; i++) begin tick = 1; step_cyc("R9"); end
        // R8: hold with and without alternate, invert bit both ways
        for (int k = 0; k < 4; k++) begin
            ssg_ctl = {2'b10, k[0], 1'b1} | {1'b0, k[1], 2'b00};
            press_key(1, "R2");
            inc_shift = 4'd12; sus_lvl = 10'd0; atk_rate = 7'd20;
            ticks_until(10, 2, "R4");
            inc_shift = 4'd7;
            for (int i = 0; i < 6; i++) begin tick = 1; step_cyc("R8"); end
            idle_inputs();
        end
        // R7: repeating-mode release caps at half range
        ssg_ctl = 4'b1000;
        press_key(1, "R2"); inc_shift = 4'd12; ticks_until(10, 2, "R4");
        press_key(0, "R2"); inc_shift = 4'd5;
        ticks_until(20, 0, "R7");

        // random phase
        for (int n = 0; n < 6000; n++) begin
            string tg;
            idle_inputs();
            tick      = ($urandom_range(0, 99) < 60);
            key_on    = ($urandom_range(0, 999) < 15);
            key_off   = ($urandom_range(0, 999) < 15);
            inc_shift = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                                    : 4'($urandom_range(0, 7));
            if ($urandom_range(0, 99) < 3) sus_lvl  = 10'($urandom_range(0, 1023));
            if ($urandom_range(0, 99) < 3) ssg_ctl  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 99) < 3) atk_rate = 7'($urandom_range(0, 127));
            total_lvl = 10'($urandom_range(0, 1023));
            tg = tag_for(m_st, ssg_ctl[3]);
            if (!ssg_ctl[3]) tg = (n % 5 == 0) ? "R10" : tg;
            step_cyc(tg);
        end
        idle_inputs();
        rst = 1; step_cyc("R1"); rst = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule